// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decoder

This block is the test access port of a memory device. A 16-state controller advances on the rising edge of the test clock under the mode-select input. An optional active-low asynchronous reset also drives it. It loads a 3-bit instruction, and the decoder uses that instruction to put one of three data registers between serial input and serial output. The three are a fixed 32-bit identification word, a single bypass bit and a boundary register of parameterised length.

The boundary register captures the device pin values. Through its latched parallel outputs it presents a pattern that has been shifted in. The decoder also produces an output-disable signal that floats the device's data outputs. The all-zeros code does not drive pins. It acts like sample/preload and additionally floats the outputs. A separate sample-with-float code keeps the outputs floated until a different instruction is updated. Serial output changes on the falling clock edge and is enabled only while shifting. The pad turns `tdo_oe` low into high impedance.

Top module: `scan_tap`

## Requirements
- R1: Five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. A low `trst_n` forces Test-Logic-Reset at once, without waiting for a clock edge.
- R2: After reset, the active instruction is identification (code 001). A data scan then shifts out the 32-bit identification value, least-significant bit first. That value has bit 0 equal to 1.
- R3: Capture-IR loads 001 into the instruction shift register. Shift-IR then sends it out least-significant bit first, so the first three bits out are 1, 0, 0.
- R4: A shifted instruction takes effect only on Update-IR. Until then, `out_hiz` and register selection keep their previous values.
- R5: Code 111 (bypass) and the reserved codes 011, 101 and 110 all select a one-bit register. That register captures 0, so a data scan returns 0 and then the input bits delayed by one position.
- R6: Under code 100 (sample/preload), Capture-DR loads `pin_in` into the boundary register. Shift-DR sends it out bit 0 first, and `out_hiz` stays low.
- R7: While captured data shifts out, the new pattern shifts in. `bsr_out` holds its value through the scan and takes the shifted pattern only on Update-DR.
- R8: Code 000 behaves like code 100 on the boundary register, and in addition drives `out_hiz` high.
- R9: Code 010 selects the boundary register and drives `out_hiz` high. `out_hiz` stays high across data scans until Update-IR loads a different code.
- R10: `tdo_oe` is high only in Shift-IR and Shift-DR. `tdo` and `tdo_oe` change on the falling edge of `tck`.
- R11: Entering Test-Logic-Reset restores the identification instruction and clears `out_hiz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High when `tdo` is to be driven |
| pin_in | input | BSR_LEN | Device pin values captured by the boundary register |
| bsr_out | output | BSR_LEN | Latched parallel outputs of the boundary cells |
| out_hiz | output | 1 | Forces the device data outputs to high impedance |

## Verification
Data scans run under every instruction class, and each one uses an asymmetric shift-in pattern, so the one-bit delay of bypass stands apart from a boundary capture. Distinct pin values and preload patterns per instruction show that capture comes from `pin_in` while `bsr_out` takes the shifted-in data. Each pair of scans also watches `out_hiz`. That separates the code that floats the outputs from the code that does not and shows that the float persists until the next instruction update. Reset is exercised both through five `tms` highs and through an asynchronous `trst_n` pulse, each one starting from a floated instruction.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] ID_CODE = 32'h1A2B_C0DF
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] bsr_out,
  output logic               out_hiz
);

  localparam int         IRW        = 3;
  localparam logic [IRW-1:0] OP_EXTEST = 3'b000;
  localparam logic [IRW-1:0] OP_IDCODE = 3'b001;
  localparam logic [IRW-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IRW-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IRW-1:0] IR_CAPT   = 3'b001;
  localparam int         IDW        = 32;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_st_e;

  tap_st_e st, st_nx;

  logic [IRW-1:0]     ir_sr, ir;
  logic [IDW-1:0]     id_sr;
  logic [BSR_LEN-1:0] bsr_sr;
  logic               byp;
  logic               sel_id, sel_bsr;

  always_comb begin
    case (st)
      S_TLR:    st_nx = tms ? S_TLR    : S_RTI;
      S_RTI:    st_nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: st_nx = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: st_nx = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  st_nx = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: st_nx = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: st_nx = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: st_nx = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: st_nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: st_nx = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: st_nx = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  st_nx = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: st_nx = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: st_nx = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: st_nx = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: st_nx = tms ? S_SEL_DR : S_RTI;
      default:  st_nx = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= S_TLR;
    else         st <= st_nx;
  end

  assign sel_id  = (ir == OP_IDCODE);
  assign sel_bsr = (ir == OP_EXTEST) || (ir == OP_SAMPZ) || (ir == OP_SAMPLE);
  assign out_hiz = (ir == OP_EXTEST) || (ir == OP_SAMPZ);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              ir_sr <= IR_CAPT;
    else if (st == S_CAP_IR)  ir_sr <= IR_CAPT;
    else if (st == S_SH_IR)   ir_sr <= {tdi, ir_sr[IRW-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)              ir <= OP_IDCODE;
    else if (st == S_TLR)     ir <= OP_IDCODE;
    else if (st == S_UPD_IR)  ir <= ir_sr;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr  <= '0;
      bsr_sr <= '0;
      byp    <= 1'b0;
    end else if (st == S_CAP_DR) begin
      if (sel_id)       id_sr  <= ID_CODE;
      else if (sel_bsr) bsr_sr <= pin_in;
      else              byp    <= 1'b0;
    end else if (st == S_SH_DR) begin
      if (sel_id)       id_sr  <= {tdi, id_sr[IDW-1:1]};
      else if (sel_bsr) bsr_sr <= (bsr_sr >> 1) | (BSR_LEN'(tdi) << (BSR_LEN-1));
      else              byp    <= tdi;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                        bsr_out <= '0;
    else if (st == S_UPD_DR && sel_bsr) bsr_out <= bsr_sr;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == S_SH_IR) || (st == S_SH_DR);
      if (st == S_SH_IR)  tdo <= ir_sr[0];
      else if (sel_id)    tdo <= id_sr[0];
      else if (sel_bsr)   tdo <= bsr_sr[0];
      else                tdo <= byp;
    end
  end

  assert_oe_in_shift_R10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st == S_SH_IR || st == S_SH_DR));

  assert_ir_held_R4: assert property (@(negedge tck) disable iff (!trst_n)
    (st != S_UPD_IR && st != S_TLR) |=> $stable(ir));

  assert_hiz_after_update_R8: assert property (@(negedge tck) disable iff (!trst_n)
    (st == S_UPD_IR && (ir_sr == OP_EXTEST || ir_sr == OP_SAMPZ)) |=> out_hiz);

  assert_tlr_restores_id_R11: assert property (@(negedge tck) disable iff (!trst_n)
    (st == S_TLR) |=> (sel_id && !out_hiz));

  assert_bypass_captures_zero_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_CAP_DR && !sel_id && !sel_bsr) |=> (byp == 1'b0));

  assert_bsr_out_held_R7: assert property (@(negedge tck) disable iff (!trst_n)
    (st != S_UPD_DR) |=> $stable(bsr_out));

endmodule

// File: tb/scan_tap_tb_top.sv
module scan_tap_tb_top;
  localparam int          CLK_PERIOD = 20;
  localparam int          NB         = 8;
  localparam logic [31:0] IDV        = 32'h1A2B_C0DF;

  logic          tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [NB-1:0] pin_in = '0;
  logic          tdo, tdo_oe, out_hiz;
  logic [NB-1:0] bsr_out;

  int n_chk = 0, n_fail = 0;

  scan_tap #(.BSR_LEN(NB), .ID_CODE(IDV)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .bsr_out(bsr_out), .out_hiz(out_hiz));

  always #(CLK_PERIOD/2) tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap, output logic hiz_before);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = tdo;
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i]);
      if (i < 2) cap[i+1] = tdo;
    end
    hiz_before = out_hiz;
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout,
                         output logic oe_sh, output logic [NB-1:0] mid_out);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = tdo; oe_sh = tdo_oe;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = tdo;
    end
    mid_out = bsr_out;
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset_state;
    logic [31:0] d; logic oe; logic [NB-1:0] m;
    chk("R11 reset out_hiz", 32'(out_hiz), 0);
    chk("R10 reset tdo_oe", 32'(tdo_oe), 0);
    step(0, 0);
    chk("R10 oe low in idle", 32'(tdo_oe), 0);
    scan_dr(32, 32'h0, d, oe, m);
    chk("R2 idcode shifted out", d, IDV);
    chk("R2 idcode bit0 is 1", 32'(d[0]), 1);
    chk("R10 oe high in shift", 32'(oe), 1);
    chk("R10 oe low after scan", 32'(tdo_oe), 0);
  endtask

  task automatic t_ir_capture;
    logic [2:0] c; logic hb;
    scan_ir(3'b000, c, hb);
    chk("R3 capture pattern", 32'(c), 32'h1);
    chk("R4 hiz before update", 32'(hb), 0);
    chk("R8 hiz after update", 32'(out_hiz), 1);
  endtask

  task automatic t_extest;
    logic [31:0] d; logic oe; logic [NB-1:0] m;
    pin_in = 8'h5A;
    scan_dr(NB, 32'hC3, d, oe, m);
    chk("R8 captured pins", d, 32'h5A);
    chk("R7 bsr_out held mid scan", 32'(m), 32'h0);
    chk("R8 bsr_out updated", 32'(bsr_out), 32'hC3);
    chk("R8 hiz held", 32'(out_hiz), 1);
  endtask

  task automatic t_sample;
    logic [2:0] c; logic hb; logic [31:0] d; logic oe; logic [NB-1:0] m;
    scan_ir(3'b100, c, hb);
    chk("R4 hiz before update", 32'(hb), 1);
    chk("R6 hiz low", 32'(out_hiz), 0);
    pin_in = 8'hA5;
    scan_dr(NB, 32'h3C, d, oe, m);
    chk("R6 captured pins", d, 32'hA5);
    chk("R7 bsr_out held mid scan", 32'(m), 32'hC3);
    chk("R7 bsr_out updated", 32'(bsr_out), 32'h3C);
  endtask

  task automatic t_sample_z;
    logic [2:0] c; logic hb; logic [31:0] d; logic oe; logic [NB-1:0] m;
    scan_ir(3'b010, c, hb);
    chk("R9 hiz set", 32'(out_hiz), 1);
    pin_in = 8'h0F;
    scan_dr(NB, 32'hF0, d, oe, m);
    chk("R9 captured pins", d, 32'h0F);
    chk("R9 bsr_out updated", 32'(bsr_out), 32'hF0);
    chk("R9 hiz kept across scan", 32'(out_hiz), 1);
    scan_ir(3'b111, c, hb);
    chk("R9 hiz until update", 32'(hb), 1);
    chk("R9 hiz cleared by new code", 32'(out_hiz), 0);
  endtask

  task automatic t_bypass;
    logic [2:0] c; logic hb; logic [31:0] d; logic oe; logic [NB-1:0] m;
    logic [2:0] codes [4] = '{3'b111, 3'b011, 3'b101, 3'b110};
    for (int k = 0; k < 4; k++) begin
      scan_ir(codes[k], c, hb);
      scan_dr(8, 32'hB2, d, oe, m);
      chk($sformatf("R5 one-bit path code %b", codes[k]), d, 32'h64);
      chk("R5 bsr_out untouched", 32'(bsr_out), 32'hF0);
    end
  endtask

  task automatic t_tms_reset;
    logic [2:0] c; logic hb; logic [31:0] d; logic oe; logic [NB-1:0] m;
    scan_ir(3'b000, c, hb);
    chk("R1 hiz before reset", 32'(out_hiz), 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R1 tms reset clears hiz", 32'(out_hiz), 0);
    step(0, 0);
    scan_dr(32, 32'h0, d, oe, m);
    chk("R11 idcode after tms reset", d, IDV);
  endtask

  task automatic t_async_reset;
    logic [2:0] c; logic hb; logic [31:0] d; logic oe; logic [NB-1:0] m;
    scan_ir(3'b010, c, hb);
    @(posedge tck); #2;
    trst_n = 1'b0; #1;
    chk("R1 async reset clears hiz", 32'(out_hiz), 0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(0, 0);
    scan_dr(32, 32'h0, d, oe, m);
    chk("R1 idcode after async reset", d, IDV);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge tck);
    #1 trst_n = 1'b1;
    t_reset_state;
    t_ir_capture;
    t_extest;
    t_sample;
    t_sample_z;
    t_bypass;
    t_tms_reset;
    t_async_reset;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule